// File: doc/BRIEF.md
# Multi-mode I/Q lane serializer

This block takes one I/Q sample pair at a time and shifts it out on one, two or four serial data lanes. It is meant to sit at the edge of a baseband data path. A sample stream enters over a valid/ready handshake. Each accepted pair becomes one frame of bits on the lanes, with the most significant bit first. A two-bit mode input chooses the lane layout:

| Code | Layout |
|------|--------|
| 0 | CMOS-style one lane |
| 1 | CMOS-style four lanes |
| 2 | LVDS-style one lane |
| 3 | LVDS-style two lanes |

A `narrow` input reduces the samples of the two-lane layout to 12 bits. A `ddr` input chooses single or double data rate for the CMOS-style layouts.

Each lane has two output bits per clock cycle. `lane_rise` is the bit for the rising half of the forwarded bit clock and `lane_fall` is the bit for the falling half. In single data rate both halves carry the same bit. `bclk_en` tells the pad logic when to forward the bit clock. `frame` marks the first cycle of every frame.

The stream input applies back-pressure. `s_ready` is high when the block is idle, and also in the final cycle of a frame, so a waiting sample continues the stream with no gap. In every other cycle of a frame `s_ready` is low. A producer may hold `s_valid` and its data for as long as it needs. Mode, `narrow` and `ddr` are sampled only at the handshake, so changing them mid-frame has no effect.

Top module: `iq_lane_ser`

## Requirements
- R1: In modes 0 and 2, lane 0 carries the 16 bits of I, MSB first, and then the 16 bits of Q, for 32 bits in total. Lanes 1 to 3 stay 0.
- R2: In mode 1, lane 0 carries I[15:8], lane 1 carries I[7:0], lane 2 carries Q[15:8] and lane 3 carries Q[7:0]. Each lane sends 8 bits, MSB first.
- R3: In mode 3 with `narrow`=0, lane 0 carries the 16 bits of I and lane 1 the 16 bits of Q, MSB first. Lanes 2 and 3 stay 0.
- R4: In mode 3 with `narrow`=1, each sample is rounded to 12 bits before it is sent, as 12 bits per lane. The 12-bit value is bits [15:4] plus bit 3, which rounds half up. A result that would pass 0x7FF saturates at 0x7FF. In all other modes `narrow` has no effect on the bits sent.
- R5: Modes 2 and 3 always use double data rate, whatever the value of `ddr`. Each cycle sends two bits per lane: the earlier bit on `lane_rise` and the next bit on `lane_fall`.
- R6: Modes 0 and 1 use double data rate when `ddr`=1. When `ddr`=0 they send one bit per lane per cycle, and `lane_fall` equals `lane_rise`.
- R7: `frame` is high for exactly one cycle, the cycle that carries the first bits of a frame. `bclk_en` is high in exactly the frame's cycles, which number bits-per-lane (or half of that in DDR). While `bclk_en` is low, all lane outputs are 0.
- R8: `s_ready` is high when idle or in the last cycle of a frame, and low otherwise. A handshake in the last cycle makes the next frame start in the following cycle.
- R9: A handshake in mode 1 with `narrow`=1 is consumed without sending anything. `err` is then high for one cycle, the cycle after the handshake.
- R10: After reset the lanes, `frame`, `bclk_en` and `err` are 0, and `s_ready` is 1.
- R11: Changes to `mode`, `narrow` or `ddr` while a frame is being sent do not alter that frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s_valid | input | 1 | Sample pair offered |
| s_ready | output | 1 | Sample pair can be taken this cycle |
| s_i | input | 16 | In-phase sample, two's complement |
| s_q | input | 16 | Quadrature sample, two's complement |
| mode | input | 2 | Lane layout: 0 CMOS one lane, 1 CMOS four lanes, 2 LVDS one lane, 3 LVDS two lanes |
| narrow | input | 1 | 12-bit samples (two-lane layout) |
| ddr | input | 1 | Double data rate for the CMOS-style layouts |
| lane_rise | output | 4 | Per-lane bit for the rising half of the bit clock |
| lane_fall | output | 4 | Per-lane bit for the falling half of the bit clock |
| frame | output | 1 | First cycle of a frame |
| bclk_en | output | 1 | Forward the bit clock this cycle |
| err | output | 1 | A four-lane request with 12-bit samples was dropped |

## Verification
The bench sends samples in every mode and rate. Among them are rounding values that sit exactly at the half-way point, just below it, at the positive saturation point and on the negative side. A rounding fault would show as an off-by-one or a wrapped sign in the lane bits. The bench also streams frames back-to-back, because a ready signal that opens one cycle late would leave a gap, and one that opens early would cut the current frame short. It changes the configuration inputs in the middle of a frame, to catch a design that reads the mode live rather than latching it. It also sends the forbidden four-lane 12-bit request, which must leave the lanes quiet and raise only `err`.

// File: rtl/iq_ser_pkg.sv
package iq_ser_pkg;
  typedef enum logic [1:0] {
    MODE_C1 = 2'd0,
    MODE_C4 = 2'd1,
    MODE_L1 = 2'd2,
    MODE_L2 = 2'd3
  } ser_mode_e;
endpackage

// File: rtl/iq_narrow.sv
// Rounds a sample to OUT_W bits, half up, with positive saturation.
// The result is left-aligned in an IN_W-bit word.
module iq_narrow #(
  parameter int IN_W  = 16,
  parameter int OUT_W = 12
) (
  input  logic [IN_W-1:0] x,
  output logic [IN_W-1:0] y
);
  localparam int DROP = IN_W - OUT_W;
  localparam logic [OUT_W-1:0] MAXPOS = {1'b0, {(OUT_W-1){1'b1}}};

  logic [OUT_W-1:0] trunc;
  logic             half;
  logic             sat;
  logic [OUT_W-1:0] rounded;

  always_comb begin
    trunc   = x[IN_W-1:DROP];
    half    = x[DROP-1];
    sat     = (trunc == MAXPOS) && half;
    rounded = sat ? MAXPOS : trunc + {{(OUT_W-1){1'b0}}, half};
    y       = {rounded, {DROP{1'b0}}};
  end
endmodule

// File: rtl/iq_lane_pack.sv
// Maps one I/Q pair onto the per-lane shift words, left-aligned.
module iq_lane_pack
  import iq_ser_pkg::*;
#(
  parameter int SW    = 16,
  parameter int LANES = 4,
  parameter int SR_W  = 2 * SW
) (
  input  logic [SW-1:0]               i_smp,
  input  logic [SW-1:0]               q_smp,
  input  logic [1:0]                  mode,
  output logic [LANES-1:0][SR_W-1:0]  load
);
  localparam int HALF = SW / 2;

  always_comb begin
    load = '0;
    case (mode)
      MODE_C1, MODE_L1: load[0] = {i_smp, q_smp};
      MODE_C4: begin
        for (int k = 0; k < LANES; k++) begin
          logic [SW-1:0] src;
          src = (k < LANES / 2) ? i_smp : q_smp;
          load[k] = (k % 2 == 0) ? {src[SW-1:HALF], {(SR_W-HALF){1'b0}}}
                                 : {src[HALF-1:0],  {(SR_W-HALF){1'b0}}};
        end
      end
      default: begin
        load[0] = {i_smp, {(SR_W-SW){1'b0}}};
        load[1] = {q_smp, {(SR_W-SW){1'b0}}};
      end
    endcase
  end
endmodule

// File: rtl/iq_shift_lane.sv
// One lane: a shift word that moves one or two bits per cycle.
module iq_shift_lane #(
  parameter int SR_W = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [SR_W-1:0] load_val,
  input  logic            shift_en,
  input  logic            two_step,
  output logic            bit_rise,
  output logic            bit_fall
);
  logic [SR_W-1:0] sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sr <= '0;
    else if (load_en)  sr <= load_val;
    else if (shift_en) sr <= two_step ? {sr[SR_W-3:0], 2'b00} : {sr[SR_W-2:0], 1'b0};
  end

  assign bit_rise = sr[SR_W-1];
  assign bit_fall = two_step ? sr[SR_W-2] : sr[SR_W-1];
endmodule

// File: rtl/iq_frame_ctl.sv
// Frame sequencer: counts the cycles of a frame and flags its first and last cycle.
module iq_frame_ctl #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [CNT_W-1:0] len,
  output logic             busy,
  output logic             first,
  output logic             last
);
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      idx   <= '0;
      len_q <= '0;
    end else if (start) begin
      busy  <= 1'b1;
      idx   <= '0;
      len_q <= len;
    end else if (busy) begin
      if (last) busy <= 1'b0;
      else      idx  <= idx + CNT_W'(1);
    end
  end

  assign first = busy && (idx == '0);
  assign last  = busy && (idx == len_q - CNT_W'(1));
endmodule

// File: rtl/iq_lane_ser.sv
module iq_lane_ser
  import iq_ser_pkg::*;
#(
  parameter int SW    = 16,
  parameter int NW    = 12,
  parameter int LANES = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [SW-1:0]    s_i,
  input  logic [SW-1:0]    s_q,
  input  logic [1:0]       mode,
  input  logic             narrow,
  input  logic             ddr,
  output logic [LANES-1:0] lane_rise,
  output logic [LANES-1:0] lane_fall,
  output logic             frame,
  output logic             bclk_en,
  output logic             err
);
  localparam int SR_W  = 2 * SW;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic hs, bad, start, busy, first, last;
  logic ddr_eff, ddr_q, use_narrow;
  logic [SW-1:0] i_nar, q_nar, i_use, q_use;
  logic [CNT_W-1:0] bits_sel, len_sel;
  logic [LANES-1:0][SR_W-1:0] load;
  logic [LANES-1:0] rise_v, fall_v;

  assign hs         = s_valid && s_ready;
  assign bad        = narrow && (mode == MODE_C4);
  assign start      = hs && !bad;
  assign ddr_eff    = mode[1] || ddr;
  assign use_narrow = narrow && (mode == MODE_L2);

  iq_narrow #(.IN_W(SW), .OUT_W(NW)) u_nar_i (.x(s_i), .y(i_nar));
  iq_narrow #(.IN_W(SW), .OUT_W(NW)) u_nar_q (.x(s_q), .y(q_nar));

  assign i_use = use_narrow ? i_nar : s_i;
  assign q_use = use_narrow ? q_nar : s_q;

  always_comb begin
    case (mode)
      MODE_C1, MODE_L1: bits_sel = CNT_W'(SR_W);
      MODE_C4:          bits_sel = CNT_W'(SW / 2);
      default:          bits_sel = narrow ? CNT_W'(NW) : CNT_W'(SW);
    endcase
    len_sel = ddr_eff ? (bits_sel >> 1) : bits_sel;
  end

  iq_lane_pack #(.SW(SW), .LANES(LANES), .SR_W(SR_W)) u_pack (
    .i_smp(i_use), .q_smp(q_use), .mode(mode), .load(load)
  );

  iq_frame_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .start(start), .len(len_sel),
    .busy(busy), .first(first), .last(last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ddr_q <= 1'b0;
      err   <= 1'b0;
    end else begin
      err <= hs && bad;
      if (start) ddr_q <= ddr_eff;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    iq_shift_lane #(.SR_W(SR_W)) u_lane (
      .clk(clk), .rst_n(rst_n), .load_en(start), .load_val(load[g]),
      .shift_en(busy), .two_step(ddr_q),
      .bit_rise(rise_v[g]), .bit_fall(fall_v[g])
    );
  end

  assign s_ready   = !busy || last;
  assign lane_rise = busy ? rise_v : '0;
  assign lane_fall = busy ? fall_v : '0;
  assign frame     = first;
  assign bclk_en   = busy;
endmodule

// File: rtl/iq_lane_ser_chk.sv
module iq_lane_ser_chk #(
  parameter int LANES = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_ready,
  input logic             frame,
  input logic             bclk_en,
  input logic             err,
  input logic             ddr_q,
  input logic [LANES-1:0] lane_rise,
  input logic [LANES-1:0] lane_fall
);
  AST_FRAME_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    frame |=> !frame); // R7
  AST_FRAME_IN_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> bclk_en); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |-> (lane_rise == '0 && lane_fall == '0)); // R7
  AST_NO_READY_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
    frame |-> !s_ready); // R8
  AST_ERR_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> !frame); // R9
  AST_SDR_HALVES_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bclk_en && !ddr_q) |-> (lane_rise == lane_fall)); // R6
  AST_IDLE_READY: assert property (@(posedge clk) disable iff (!rst_n)
    !bclk_en |-> s_ready); // R8
endmodule

bind iq_lane_ser iq_lane_ser_chk #(.LANES(LANES)) u_chk (
  .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .frame(frame),
  .bclk_en(bclk_en), .err(err), .ddr_q(ddr_q),
  .lane_rise(lane_rise), .lane_fall(lane_fall)
);

// File: tb/iq_lane_ser_test.sv
`timescale 1ns/1ps
module iq_lane_ser_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0;
  logic s_ready;
  logic [15:0] s_i = '0, s_q = '0;
  logic [1:0] mode = '0;
  logic narrow = 1'b0, ddr = 1'b0;
  logic [3:0] lane_rise, lane_fall;
  logic frame, bclk_en, err;

  int checks = 0;
  int errors = 0;
  bit took;
  bit err_next = 0;

  logic [3:0] q_rise[$];
  logic [3:0] q_fall[$];
  bit         q_frm[$];
  string      q_tag[$];

  always #2 clk = ~clk;

  iq_lane_ser uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_i(s_i), .s_q(s_q), .mode(mode), .narrow(narrow), .ddr(ddr),
    .lane_rise(lane_rise), .lane_fall(lane_fall), .frame(frame),
    .bclk_en(bclk_en), .err(err)
  );

  task automatic chk(bit ok, string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [11:0] rnd12(logic [15:0] x);
    int v;
    v = $signed(x);
    v = (v + 8) >>> 4;
    if (v > 2047) v = 2047;
    return v[11:0];
  endfunction

  // Behavioural model: per-lane bit lists, consumed one or two bits per cycle.
  task automatic push_frame(logic [15:0] i, logic [15:0] q, logic [1:0] m, bit nar, bit d);
    bit lb[4][$];
    bit two;
    string tag;
    bit first = 1;
    two = m[1] || d;
    case (m)
      2'd0: tag = d ? "R1 R6 ddr" : "R1 R6 sdr";
      2'd1: tag = d ? "R2 R6 ddr" : "R2 R6 sdr";
      2'd2: tag = "R1 R5";
      default: tag = nar ? "R4 R5" : "R3 R5";
    endcase
    if (m == 2'd0 || m == 2'd2) begin
      for (int b = 15; b >= 0; b--) lb[0].push_back(i[b]);
      for (int b = 15; b >= 0; b--) lb[0].push_back(q[b]);
    end else if (m == 2'd1) begin
      for (int b = 15; b >= 8; b--) lb[0].push_back(i[b]);
      for (int b = 7; b >= 0; b--)  lb[1].push_back(i[b]);
      for (int b = 15; b >= 8; b--) lb[2].push_back(q[b]);
      for (int b = 7; b >= 0; b--)  lb[3].push_back(q[b]);
    end else if (nar) begin
      logic [11:0] ri, rq;
      ri = rnd12(i);
      rq = rnd12(q);
      for (int b = 11; b >= 0; b--) begin
        lb[0].push_back(ri[b]);
        lb[1].push_back(rq[b]);
      end
    end else begin
      for (int b = 15; b >= 0; b--) begin
        lb[0].push_back(i[b]);
        lb[1].push_back(q[b]);
      end
    end
    while (lb[0].size() > 0) begin
      logic [3:0] r, f;
      r = '0;
      f = '0;
      for (int l = 0; l < 4; l++) begin
        if (lb[l].size() > 0) begin
          r[l] = lb[l].pop_front();
          f[l] = r[l];
          if (two) f[l] = lb[l].pop_front();
        end
      end
      q_rise.push_back(r);
      q_fall.push_back(f);
      q_frm.push_back(first);
      q_tag.push_back(tag);
      first = 0;
    end
  endtask

  task automatic tick();
    bit exp_rdy;
    logic [3:0] er, ef;
    bit efrm, ebusy;
    string tag;
    #1;
    exp_rdy = (q_rise.size() == 0);
    chk(s_ready === exp_rdy, "R8", "s_ready", 32'(s_ready), 32'(exp_rdy));
    took = 0;
    if (s_valid && exp_rdy) begin
      took = 1;
      if (mode == 2'd1 && narrow) err_next = 1;
      else push_frame(s_i, s_q, mode, narrow, ddr);
    end
    @(posedge clk);
    @(negedge clk);
    chk(err === err_next, "R9", "err", 32'(err), 32'(err_next));
    err_next = 0;
    if (q_rise.size() > 0) begin
      er = q_rise.pop_front();
      ef = q_fall.pop_front();
      efrm = q_frm.pop_front();
      tag = q_tag.pop_front();
      ebusy = 1;
    end else begin
      er = '0; ef = '0; efrm = 0; ebusy = 0; tag = "R7 idle";
    end
    chk({lane_rise, lane_fall} === {er, ef}, tag, "lanes",
        32'({lane_rise, lane_fall}), 32'({er, ef}));
    chk({frame, bclk_en} === {efrm, ebusy}, "R7", "frame/bclk_en",
        32'({frame, bclk_en}), 32'({efrm, ebusy}));
  endtask

  task automatic send(logic [15:0] i, logic [15:0] q, logic [1:0] m, bit nar, bit d);
    s_valid = 1; s_i = i; s_q = q; mode = m; narrow = nar; ddr = d;
    do tick(); while (!took);
  endtask

  task automatic idle(int n, bit junk);
    s_valid = 0;
    for (int k = 0; k < n; k++) begin
      if (junk) begin  // R11: config inputs wander while a frame runs
        mode = 2'(k); narrow = k[0]; ddr = ~k[1];
        s_i = 16'(k * 977); s_q = ~s_i;
      end
      tick();
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk({lane_rise, lane_fall, frame, bclk_en, err} === '0, "R10", "reset outputs",
          32'({lane_rise, lane_fall, frame, bclk_en, err}), 0);
      chk(s_ready === 1'b1, "R10", "reset ready", 32'(s_ready), 1);
    end
    rst_n = 1;
    idle(2, 0);
    send(16'hA5C3, 16'h1234, 2'd0, 0, 0); idle(34, 0);   // R1 R6 SDR
    send(16'h0F0F, 16'hF00D, 2'd0, 0, 1); idle(18, 0);   // R1 R6 DDR
    send(16'h8E71, 16'h3CA9, 2'd1, 0, 0); idle(10, 0);   // R2 SDR
    send(16'h5AC3, 16'h96E1, 2'd1, 0, 1); idle(6, 0);    // R2 DDR
    send(16'hC001, 16'h7FFE, 2'd2, 0, 0); idle(18, 0);   // R5: ddr=0 ignored
    send(16'hBEEF, 16'h4321, 2'd3, 0, 0); idle(10, 0);   // R3
    send(16'h7FF8, 16'h8008, 2'd3, 1, 0); idle(8, 0);    // R4 saturate / negative
    send(16'h1238, 16'h1237, 2'd3, 1, 1); idle(8, 0);    // R4 half / below half
    send(16'hFFF8, 16'h0007, 2'd3, 1, 0); idle(8, 0);    // R4 around zero
    send(16'h1111, 16'h2222, 2'd0, 1, 0); idle(34, 0);   // R4: narrow ignored in mode 0
    send(16'h1234, 16'h5678, 2'd1, 1, 1); idle(4, 0);    // R9 rejected
    // R8: back-to-back stream across modes
    send(16'h0123, 16'h4567, 2'd1, 0, 1);
    send(16'h89AB, 16'hCDEF, 2'd3, 1, 1);
    send(16'hFEDC, 16'hBA98, 2'd0, 0, 1);
    send(16'h7654, 16'h3210, 2'd1, 1, 0);                // R9 on a last cycle
    send(16'h2468, 16'h1357, 2'd2, 0, 0);
    idle(20, 0);
    send(16'hDEAD, 16'hCAFE, 2'd0, 0, 0); idle(36, 1);   // R11
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule